// File: doc/BRIEF.md
# Two-Class Crosspoint Cell Controller

This controller sits at one crosspoint of an output column in a crosspoint-buffered switch, at position `POS` counted from the top (1-based). Each clock is one cell time. Cells reach it from two places: the local input line, and the crosspoint directly above, which forwards cells into this crosspoint's transit storage. Each cell time the controller sends at most one cell to the crosspoint below, or to the output line if it is the bottom one. It tracks cell descriptors (stamps) only. The payload path and the address filter that admits local cells sit outside the block.

Cells fall into two classes, and the high class has strict priority. High cells carry a timestamp taken from a counter that runs in step across the switch. The older of the local and transit high heads is sent, and ties are broken by a deterministic rotation. Low cells carry the identifier of the input they came from. Low transit cells are sorted into one virtual queue per upstream input, and a round-robin ring over those queues and the local low buffer shares the spare bandwidth fairly by throughput. Two backpressure signals from below, one per class, stop transmission. The controller raises its own two backpressure signals upward before its transit storage is full.

Top module: `xpq_crosspoint_ctrl`

## Requirements
- R1: A local high cell takes the value of `sync_time` in its arrival cycle as its stamp. A local low cell is sent with `out_tag` equal to `POS`.
- R2: A low transit cell whose identifier `up_tag` = i, with 1 <= i <= POS-1, is stored in virtual queue i. A low transit cell with identifier 0 or any identifier of POS or above is discarded and is never sent.
- R3: While `dn_nack_hi` is 1, `out_vld` is 0 and no stored cell is consumed.
- R4: A low cell is sent (`out_vld`=1, `out_hi`=0) only when both high buffers are empty and `dn_nack_lo` is 0. `out_hi`=1 marks a high cell.
- R5: When both high heads are present and their stamps differ, the older one is sent. Stamp a is older than stamp b when (b - a) mod 2^STAMP_W lies in 1 .. 2^(STAMP_W-1)-1. `out_local`=1 means the local buffer.
- R6: On equal high stamps, a tie counter that starts at 0 after reset chooses the local head when it is 0 and the transit head otherwise. The counter steps modulo POS on each tie that is sent, so the local side wins one tie in POS.
- R7: The low ring orders its requesters by identifier, with queue i as identifier i and the local low buffer as identifier POS. It searches from a start identifier that is 1 after reset. After a low grant to identifier g, the start becomes g+1, wrapping from POS to 1. It changes only on a low grant. `out_tag` carries g.
- R8: `up_nack_hi` is 1 exactly when transit high occupancy is at least HI_DEPTH-MARGIN. `up_nack_lo` is 1 exactly when some virtual queue holds at least LO_DEPTH-MARGIN cells.
- R9: An arrival to a buffer that is full at the start of the cycle is dropped. Each high buffer sends its cells in arrival order.
- R10: After reset all storage is empty, and `out_vld`, `up_nack_hi` and `up_nack_lo` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one cell time per cycle |
| rst | input | 1 | Synchronous active-high reset |
| sync_time | input | 8 | Switch-wide synchronized cell-time counter |
| loc_vld | input | 1 | A local cell arrives |
| loc_hi | input | 1 | Class of the local cell, 1 = high |
| up_vld | input | 1 | A cell arrives from the crosspoint above |
| up_hi | input | 1 | Class of the cell from above, 1 = high |
| up_tag | input | 8 | Stamp of the cell from above: timestamp (high) or input identifier (low) |
| dn_nack_hi | input | 1 | High-class backpressure from below |
| dn_nack_lo | input | 1 | Low-class backpressure from below |
| out_vld | output | 1 | A cell is sent this cycle |
| out_hi | output | 1 | Class of the sent cell |
| out_local | output | 1 | Sent cell came from local storage (1) or transit storage (0) |
| out_tag | output | 8 | Stamp of the sent cell |
| up_nack_hi | output | 1 | High-class backpressure to the crosspoint above |
| up_nack_lo | output | 1 | Low-class backpressure to the crosspoint above |

## Verification
Equal high stamps at both heads are the hardest case to reach. So is a stamp comparison that crosses the counter wrap. Random traffic almost never lines either one up. The stimulus holds `dn_nack_hi` high so that nothing drains, loads both high buffers with identical stamps, and then releases the hold to walk the tie counter through a full rotation. It repeats this with stamps on either side of the wrap (250 against 3). The same hold-and-release pattern fills buffers past their depth and sends out-of-range identifiers, and random traffic with backpressure from below then covers the ring.

// File: rtl/xpq_pkg.sv
package xpq_pkg;
    localparam int STAMP_W = 8;

    typedef logic [STAMP_W-1:0] stamp_t;

    typedef enum logic {
        ORIG_TRANSIT = 1'b0,
        ORIG_LOCAL   = 1'b1
    } orig_e;

    // Head of a high-class buffer: request plus its stamp.
    typedef struct packed {
        logic   req;
        stamp_t stamp;
    } hi_head_t;

    // One cell-time transfer decision.
    typedef struct packed {
        logic   vld;
        logic   hi;
        orig_e  orig;
        stamp_t tag;
    } xfer_t;

    // True when stamp a was taken strictly earlier than stamp b (wrap-aware).
    function automatic logic stamp_older(input stamp_t a, input stamp_t b);
        stamp_t gap;
        gap = b - a;
        return (gap != '0) && !gap[STAMP_W-1];
    endfunction
endpackage

// File: rtl/xpq_stamp_fifo.sv
module xpq_stamp_fifo
    import xpq_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  stamp_t        din,
    input  logic          pop,
    output hi_head_t      head,
    output logic [CW-1:0] count
);
    stamp_t        mem [DEPTH];
    logic [PW-1:0] rd_p, wr_p;
    logic          do_push, do_pop;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    assign do_push    = push && (count != CW'(DEPTH));
    assign do_pop     = pop && head.req;
    assign head.req   = (count != '0);
    assign head.stamp = mem[rd_p];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_p] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_p  <= '0;
            wr_p  <= '0;
            count <= '0;
        end else begin
            if (do_push) wr_p <= bump(wr_p);
            if (do_pop)  rd_p <= bump(rd_p);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    assert_fifo_bound_R9: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));
    assert_fifo_full_drop_R9: assert property (@(posedge clk) disable iff (rst)
        (count == CW'(DEPTH) && !pop) |=> count == CW'(DEPTH));
endmodule

// File: rtl/xpq_lo_vq_bank.sv
module xpq_lo_vq_bank #(
    parameter int NQ     = 3,
    parameter int DEPTH  = 4,
    parameter int MARGIN = 1,
    parameter int IDW    = 8,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           push,
    input  logic [IDW-1:0] push_id,
    input  logic           pop,
    input  logic [IDW-1:0] pop_id,
    output logic [NQ-1:0]  req,
    output logic           almost_full
);
    logic [NQ-1:0] near;

    for (genvar q = 0; q < NQ; q++) begin : g_vq
        logic [CW-1:0] cnt;
        logic          hit_in, hit_out;

        assign hit_in  = push && (push_id == IDW'(q + 1)) && (cnt != CW'(DEPTH));
        assign hit_out = pop && (pop_id == IDW'(q + 1)) && (cnt != '0);
        assign req[q]  = (cnt != '0);
        assign near[q] = (cnt >= CW'(DEPTH - MARGIN));

        always_ff @(posedge clk) begin
            if (rst) cnt <= '0;
            else     cnt <= cnt + CW'(hit_in) - CW'(hit_out);
        end

        assert_vq_bound_R9: assert property (@(posedge clk) disable iff (rst)
            cnt <= CW'(DEPTH));
        assert_vq_pop_nonempty_R7: assert property (@(posedge clk) disable iff (rst)
            (pop && pop_id == IDW'(q + 1)) |-> req[q]);
    end

    assign almost_full = |near;
endmodule

// File: rtl/xpq_ring_pick.sv
module xpq_ring_pick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] start,
    output logic          any,
    output logic [IW-1:0] win
);
    int s;

    // Scan from the farthest offset down so the nearest requester wins.
    always_comb begin
        any = 1'b0;
        win = start;
        s   = 0;
        for (int off = N - 1; off >= 0; off--) begin
            s = int'(start) + off;
            if (s >= N) s = s - N;
            if (req[s]) begin
                any = 1'b1;
                win = IW'(s);
            end
        end
    end
endmodule

// File: rtl/xpq_crosspoint_ctrl.sv
module xpq_crosspoint_ctrl
    import xpq_pkg::*;
#(
    parameter int POS       = 4,
    parameter int LOC_DEPTH = 4,
    parameter int HI_DEPTH  = 4,
    parameter int LO_DEPTH  = 4,
    parameter int MARGIN    = 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [STAMP_W-1:0]  sync_time,
    input  logic                loc_vld,
    input  logic                loc_hi,
    input  logic                up_vld,
    input  logic                up_hi,
    input  logic [STAMP_W-1:0]  up_tag,
    input  logic                dn_nack_hi,
    input  logic                dn_nack_lo,
    output logic                out_vld,
    output logic                out_hi,
    output logic                out_local,
    output logic [STAMP_W-1:0]  out_tag,
    output logic                up_nack_hi,
    output logic                up_nack_lo
);
    localparam int IW  = $clog2(POS);
    localparam int LCW = $clog2(LOC_DEPTH + 1);
    localparam int XCW = $clog2(LOC_DEPTH + 1);
    localparam int HCW = $clog2(HI_DEPTH + 1);

    hi_head_t         hx_head, ht_head;
    logic [XCW-1:0]   hx_cnt;
    logic [HCW-1:0]   ht_cnt;
    logic [LCW-1:0]   lx_cnt;
    logic [POS-2:0]   vq_req;
    logic [POS-1:0]   ring_req;
    logic [IW-1:0]    ring_ptr, lo_win;
    logic [IW-1:0]    tie_cnt;
    logic             lo_any, win_local;
    logic             hi_any, hi_tie, hi_local, send_hi, send_lo;
    logic             lx_in, lx_out;
    xfer_t            pick;

    // ---------------- storage ----------------
    xpq_stamp_fifo #(.DEPTH(LOC_DEPTH)) u_loc_hi (
        .clk(clk), .rst(rst),
        .push(loc_vld && loc_hi), .din(sync_time),
        .pop(send_hi && hi_local),
        .head(hx_head), .count(hx_cnt)
    );

    xpq_stamp_fifo #(.DEPTH(HI_DEPTH)) u_trn_hi (
        .clk(clk), .rst(rst),
        .push(up_vld && up_hi), .din(up_tag),
        .pop(send_hi && !hi_local),
        .head(ht_head), .count(ht_cnt)
    );

    xpq_lo_vq_bank #(.NQ(POS - 1), .DEPTH(LO_DEPTH), .MARGIN(MARGIN), .IDW(STAMP_W)) u_vq (
        .clk(clk), .rst(rst),
        .push(up_vld && !up_hi), .push_id(up_tag),
        .pop(send_lo && !win_local), .pop_id(stamp_t'(lo_win) + stamp_t'(1)),
        .req(vq_req), .almost_full(up_nack_lo)
    );

    assign lx_in  = loc_vld && !loc_hi && (lx_cnt != LCW'(LOC_DEPTH));
    assign lx_out = send_lo && win_local;

    always_ff @(posedge clk) begin
        if (rst) lx_cnt <= '0;
        else     lx_cnt <= lx_cnt + LCW'(lx_in) - LCW'(lx_out);
    end

    // ---------------- high class: age order with rotating tie-break ----------------
    assign hi_any   = hx_head.req || ht_head.req;
    assign hi_tie   = hx_head.req && ht_head.req && (hx_head.stamp == ht_head.stamp);
    assign hi_local = hx_head.req &&
                      (!ht_head.req || stamp_older(hx_head.stamp, ht_head.stamp) ||
                       (hi_tie && tie_cnt == '0));
    assign send_hi  = !dn_nack_hi && hi_any;

    // ---------------- low class: ring over identifiers 1..POS ----------------
    assign ring_req  = {(lx_cnt != '0), vq_req};
    assign win_local = (lo_win == IW'(POS - 1));
    assign send_lo   = !dn_nack_hi && !dn_nack_lo && !hi_any && lo_any;

    xpq_ring_pick #(.N(POS), .IW(IW)) u_ring (
        .req(ring_req), .start(ring_ptr), .any(lo_any), .win(lo_win)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ring_ptr <= '0;
            tie_cnt  <= '0;
        end else begin
            if (send_lo)
                ring_ptr <= win_local ? '0 : lo_win + IW'(1);
            if (send_hi && hi_tie)
                tie_cnt <= (tie_cnt == IW'(POS - 1)) ? '0 : tie_cnt + IW'(1);
        end
    end

    // ---------------- transfer decision ----------------
    always_comb begin
        pick = '0;
        if (send_hi) begin
            pick.vld  = 1'b1;
            pick.hi   = 1'b1;
            pick.orig = hi_local ? ORIG_LOCAL : ORIG_TRANSIT;
            pick.tag  = hi_local ? hx_head.stamp : ht_head.stamp;
        end else if (send_lo) begin
            pick.vld  = 1'b1;
            pick.orig = win_local ? ORIG_LOCAL : ORIG_TRANSIT;
            pick.tag  = stamp_t'(lo_win) + stamp_t'(1);
        end
    end

    assign out_vld    = pick.vld;
    assign out_hi     = pick.hi;
    assign out_local  = (pick.orig == ORIG_LOCAL);
    assign out_tag    = pick.tag;
    assign up_nack_hi = (ht_cnt >= HCW'(HI_DEPTH - MARGIN));

    // ---------------- assertions ----------------
    assert_hold_on_hi_nack_R3: assert property (@(posedge clk) disable iff (rst)
        dn_nack_hi |-> !out_vld);
    assert_hold_keeps_store_R3: assert property (@(posedge clk) disable iff (rst)
        (dn_nack_hi && !(loc_vld && loc_hi) && !(up_vld && up_hi)) |=>
            ($stable(hx_cnt) && $stable(ht_cnt)));
    assert_lo_yields_R4: assert property (@(posedge clk) disable iff (rst)
        (out_vld && !out_hi) |-> (!hx_head.req && !ht_head.req && !dn_nack_lo));
    assert_lo_tag_range_R1: assert property (@(posedge clk) disable iff (rst)
        (out_vld && !out_hi) |-> (out_tag >= stamp_t'(1) && out_tag <= stamp_t'(POS)));
    assert_ring_advance_R7: assert property (@(posedge clk) disable iff (rst)
        (out_vld && !out_hi) |=>
            (ring_ptr == (($past(out_tag) == stamp_t'(POS)) ? '0 : IW'($past(out_tag)))));
    assert_ring_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !(out_vld && !out_hi) |=> $stable(ring_ptr));
    assert_loc_lo_bound_R9: assert property (@(posedge clk) disable iff (rst)
        lx_cnt <= LCW'(LOC_DEPTH));
endmodule

// File: tb/xpq_crosspoint_ctrl_test.sv
module xpq_crosspoint_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int POS = 4;
    localparam int XD  = 4;
    localparam int HD  = 4;
    localparam int LD  = 4;
    localparam int MG  = 1;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] sync_time = '0;
    logic       loc_vld = 1'b0, loc_hi = 1'b0;
    logic       up_vld = 1'b0, up_hi = 1'b0;
    logic [7:0] up_tag = '0;
    logic       dn_nack_hi = 1'b0, dn_nack_lo = 1'b0;
    logic       out_vld, out_hi, out_local, up_nack_hi, up_nack_lo;
    logic [7:0] out_tag;

    int nchk = 0;
    int nbad = 0;
    int nsent = 0;

    // reference model state
    int mhx[$];
    int mht[$];
    int mlx;
    int mvq[POS];
    int mptr;   // start identifier index 0..POS-1 (identifier = index+1)
    int mtie;

    // expected outputs
    bit e_vld, e_hi, e_loc, e_tie;
    int e_tag, e_gidx;

    always #(CLK_PERIOD / 2) clk = ~clk;

    xpq_crosspoint_ctrl #(.POS(POS), .LOC_DEPTH(XD), .HI_DEPTH(HD), .LO_DEPTH(LD), .MARGIN(MG)) uut (
        .clk(clk), .rst(rst), .sync_time(sync_time),
        .loc_vld(loc_vld), .loc_hi(loc_hi),
        .up_vld(up_vld), .up_hi(up_hi), .up_tag(up_tag),
        .dn_nack_hi(dn_nack_hi), .dn_nack_lo(dn_nack_lo),
        .out_vld(out_vld), .out_hi(out_hi), .out_local(out_local), .out_tag(out_tag),
        .up_nack_hi(up_nack_hi), .up_nack_lo(up_nack_lo)
    );

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit older(input int a, input int b);
        int d;
        d = (b - a) & 255;
        return (d != 0) && (d < 128);
    endfunction

    function automatic void model_reset();
        mhx.delete();
        mht.delete();
        mlx = 0;
        for (int i = 0; i < POS; i++) mvq[i] = 0;
        mptr = 0;
        mtie = 0;
    endfunction

    function automatic void predict();
        bit hl;
        e_vld = 0; e_hi = 0; e_loc = 0; e_tag = 0; e_tie = 0; e_gidx = -1;
        if (dn_nack_hi) return;
        if (mhx.size() > 0 || mht.size() > 0) begin
            e_tie = (mhx.size() > 0) && (mht.size() > 0) && (mhx[0] == mht[0]);
            hl = (mht.size() == 0) ||
                 ((mhx.size() > 0) && (older(mhx[0], mht[0]) || (e_tie && mtie == 0)));
            e_vld = 1; e_hi = 1; e_loc = hl;
            e_tag = hl ? mhx[0] : mht[0];
        end else if (!dn_nack_lo) begin
            for (int off = 0; off < POS; off++) begin
                int idx;
                bit rq;
                idx = (mptr + off) % POS;
                rq = (idx == POS - 1) ? (mlx > 0) : (mvq[idx] > 0);
                if (rq && e_gidx < 0) e_gidx = idx;
            end
            if (e_gidx >= 0) begin
                e_vld = 1;
                e_loc = (e_gidx == POS - 1);
                e_tag = e_gidx + 1;
            end
        end
    endfunction

    function automatic void model_advance();
        bit acc_hx, acc_ht, acc_lx, acc_vq;
        int vid;
        acc_hx = loc_vld && loc_hi && (mhx.size() < XD);
        acc_lx = loc_vld && !loc_hi && (mlx < XD);
        acc_ht = up_vld && up_hi && (mht.size() < HD);
        vid = int'(up_tag);
        acc_vq = up_vld && !up_hi && vid >= 1 && vid <= POS - 1 && mvq[(vid >= 1 && vid <= POS - 1) ? vid - 1 : 0] < LD;
        if (e_vld && e_hi) begin
            if (e_loc) void'(mhx.pop_front());
            else       void'(mht.pop_front());
            if (e_tie) mtie = (mtie + 1) % POS;
        end else if (e_vld) begin
            if (e_gidx == POS - 1) mlx--;
            else                   mvq[e_gidx]--;
            mptr = (e_gidx + 1) % POS;
        end
        if (acc_hx) mhx.push_back(int'(sync_time));
        if (acc_ht) mht.push_back(int'(up_tag));
        if (acc_lx) mlx++;
        if (acc_vq) mvq[vid - 1]++;
    endfunction

    task automatic step(input logic lv, input logic lh, input logic uv, input logic uh,
                        input logic [7:0] ut, input logic nh, input logic nl, input logic [7:0] st);
        bit anyfull;
        @(negedge clk);
        loc_vld = lv; loc_hi = lh; up_vld = uv; up_hi = uh; up_tag = ut;
        dn_nack_hi = nh; dn_nack_lo = nl; sync_time = st;
        #1;
        predict();
        chk(nh ? "R3" : (e_vld && !e_hi) ? "R7" : "R5", int'(out_vld), int'(e_vld));
        chk("R4", int'(out_hi), int'(e_hi));
        if (e_vld) begin
            chk(e_tie ? "R6" : "R5", int'(out_local), int'(e_loc));
            chk((e_vld && e_hi) ? "R9" : "R1", int'(out_tag), e_tag);
        end
        anyfull = 0;
        for (int i = 0; i < POS - 1; i++) if (mvq[i] >= LD - MG) anyfull = 1;
        chk("R8", int'(up_nack_hi), int'(mht.size() >= HD - MG));
        chk("R8", int'(up_nack_lo), int'(anyfull));
        if (out_vld) nsent++;
        model_advance();
    endtask

    task automatic idle(input int n, input logic nh, input logic nl);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 8'd0, nh, nl, sync_time);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    initial begin
        int sent0;
        logic [7:0] stime;
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R10: reset state
        chk("R10", int'(out_vld), 0);
        chk("R10", int'(up_nack_hi), 0);
        chk("R10", int'(up_nack_lo), 0);

        // R1: local low cell carries POS, local high carries sync_time
        step(1, 0, 0, 0, 8'd0, 1, 0, 8'd77);
        step(1, 1, 0, 0, 8'd0, 1, 0, 8'd91);
        step(0, 0, 0, 0, 8'd0, 0, 0, 8'd92);
        chk("R1", int'(out_tag), 91);
        idle(3, 0, 0);

        // R6: four tied pairs loaded while held, then released
        for (int i = 0; i < POS; i++) step(1, 1, 1, 1, 8'd50, 1, 0, 8'd50);
        step(0, 0, 0, 0, 8'd0, 0, 0, 8'd60);
        chk("R6", int'(out_local), 1);
        idle(10, 0, 0);

        // R5: comparisons across the counter wrap
        step(1, 1, 1, 1, 8'd250, 1, 0, 8'd3);
        step(0, 0, 0, 0, 8'd0, 0, 0, 8'd4);
        chk("R5", int'(out_local), 0);
        idle(2, 0, 0);
        step(1, 1, 1, 1, 8'd3, 1, 0, 8'd250);
        step(0, 0, 0, 0, 8'd0, 0, 0, 8'd251);
        chk("R5", int'(out_local), 1);
        idle(2, 0, 0);

        // R2: out-of-range identifiers are discarded
        step(0, 0, 1, 0, 8'd0, 1, 0, 8'd10);
        step(0, 0, 1, 0, 8'(POS), 1, 0, 8'd11);
        step(0, 0, 1, 0, 8'(POS + 5), 1, 0, 8'd12);
        step(0, 0, 0, 0, 8'd0, 0, 0, 8'd13);
        chk("R2", int'(out_vld), 0);

        // R9 and R8: overfill local and transit high while held
        for (int i = 0; i < XD + 2; i++) step(1, 1, 1, 1, 8'(20 + i), 1, 0, 8'(30 + i));
        chk("R8", int'(up_nack_hi), 1);
        sent0 = nsent;
        idle(XD + HD + 4, 0, 0);
        chk("R9", nsent - sent0, XD + HD);

        // R7 and R8: fill each virtual queue and the local low buffer, drain by ring
        for (int i = 0; i < LD; i++) begin
            for (int q = 1; q < POS; q++) step(0, 0, 1, 0, 8'(q), 0, 1, 8'd0);
            step(1, 0, 0, 0, 8'd0, 0, 1, 8'd0);
        end
        chk("R8", int'(up_nack_lo), 1);
        idle(4 * POS + 2, 0, 0);

        // R4 and R7: random traffic with backpressure
        stime = 8'd100;
        for (int i = 0; i < 4000; i++) begin
            logic uh;
            logic [7:0] ut;
            uh = 1'($urandom % 2);
            ut = uh ? stime - 8'($urandom % 20) : 8'($urandom % (POS + 1));
            step(1'($urandom % 2), 1'($urandom % 2), 1'(($urandom % 3) != 0), uh, ut,
                 1'(($urandom % 5) == 0), 1'(($urandom % 4) == 0), stime);
            stime = stime + 8'd1;
        end
        idle(60, 0, 0);
        chk("R10", int'(out_vld), 0);

        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end
endmodule